// File: doc/BRIEF.md
# Bus-mastering debug client

This block sits between the decoder of a serial debug link and a shared on-chip bus that several masters use. The host sends requests through the decoder. A bus read or a bus write is carried out by the client as a bus master. Because the client does not filter the address, a request can reach the memory-mapped debug registers of any processor on the bus, or any other location the bus can address. This is the read/write mode of operation: the host decides every access.

For debugging with monitor software, the block also holds a one-word mailbox. Code running on a processor writes the mailbox through a dedicated write port. The host stays the master and polls: it reads a status word to see whether the mailbox is full, then reads the mailbox.

The client requests the bus at a programmable two-bit priority. After reset this priority is the lowest level, so real-time masters are served first. Errors are kept in a sticky flag that the host can read at any time.

Top module: `dbg_bus_client`

## Requirements
- R1: After reset, bus_req is 0, bus_prio is 0 (the lowest level), and the status word reads 0 (not busy, no error, mailbox empty).
- R2: A host request with host_op=0 (bus read) raises bus_req with bus_we=0 and host_addr on bus_addr. bus_req, bus_addr, bus_we and bus_wdata hold steady until bus_gnt is seen. The cycle after bus_ack is sampled, rsp_bus_valid pulses for one cycle with the bus_rdata that was sampled.
- R3: A host request with host_op=1 (bus write) raises bus_req with bus_we=1 and host_wdata on bus_wdata. On completion, rsp_bus_valid pulses with rsp_bus_data equal to 0.
- R4: The client places any host_addr value on bus_addr unchanged, whether the address is low, mid-range or at the top of the range.
- R5: If bus_err is sampled during an access, the access ends. rsp_bus_valid pulses with rsp_bus_err=1 and rsp_bus_data=0, and the sticky error flag is set.
- R6: A bus read or bus write request that arrives while the client is busy is dropped, so no second bus access takes place, and the error flag is set.
- R7: host_op=2 (status read) can be issued at any time, including while busy. One cycle later rsp_loc_valid pulses with a status word in which bit 0 is busy, bit 1 is error, bit 2 is mailbox full and bits 4:3 are the priority. The read clears the error flag, unless an error is raised in the same cycle.
- R8: A write on cpu_mbox_we stores cpu_mbox_wdata and sets mailbox full. host_op=3 (mailbox read) returns the stored word on rsp_loc_data one cycle later and clears mailbox full. If the CPU write and the host read happen in the same cycle, mailbox full stays set and the read returns the word held before that write.
- R9: host_op=4 (priority write) loads host_wdata[1:0] into bus_prio on the next clock edge, and it does so even while an access is in progress.
- R10: bus_req drops in the cycle after bus_gnt is sampled. Each grant causes exactly one bus transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | One-cycle host request strobe |
| host_op | input | 3 | Operation: 0 bus read, 1 bus write, 2 status read, 3 mailbox read, 4 priority write |
| host_addr | input | AW | Bus address for bus operations |
| host_wdata | input | DW | Write data, or the new priority in bits 1:0 |
| rsp_loc_valid | output | 1 | Response pulse for a status read or mailbox read |
| rsp_loc_data | output | DW | Status word or mailbox word |
| rsp_bus_valid | output | 1 | Completion pulse for a bus access |
| rsp_bus_data | output | DW | Read data; 0 for writes and for errors |
| rsp_bus_err | output | 1 | The completed access ended in a bus error |
| cpu_mbox_we | input | 1 | Monitor software writes the mailbox |
| cpu_mbox_wdata | input | DW | Mailbox write data |
| bus_req | output | 1 | Bus request |
| bus_prio | output | 2 | Request priority, 0 lowest |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | AW | Bus address |
| bus_we | output | 1 | Bus write enable |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data, valid with bus_ack |
| bus_ack | input | 1 | Transfer completed |
| bus_err | input | 1 | Transfer failed |

## Verification
The tests run bus reads and writes with grant delays of zero to several cycles, so that a response arriving right after the grant can be told apart from one that arrives after a long wait. Addresses are chosen in the low, middle and top parts of the range, and the bench's bus model aliases two of them to the same word: if a write then a read of different addresses returns the written word, the address reached the bus whole. Error-address transfers show the zeroed data and how the sticky flag behaves across successive status reads. A second request issued during a slow grant, a status read taken while busy, and a CPU write that coincides with a host read cover the collision cases.

// File: rtl/dbg_client_pkg.sv
// Package: shared operation codes, FSM states and status word layout
// for the bus-mastering debug client.
package dbg_client_pkg;

    localparam int PRIO_W = 2;

    // Host operation codes carried on host_op.
    typedef enum logic [2:0] {
        OP_BUS_RD  = 3'd0,
        OP_BUS_WR  = 3'd1,
        OP_STAT_RD = 3'd2,
        OP_MBOX_RD = 3'd3,
        OP_PRIO_WR = 3'd4
    } host_op_e;

    // Bus master sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } bus_st_e;

    // Bit positions in the status word.
    localparam int STAT_BUSY    = 0;
    localparam int STAT_ERR     = 1;
    localparam int STAT_FULL    = 2;
    localparam int STAT_PRIO_LO = 3;

endpackage

// File: rtl/dbg_bus_fsm.sv
// Module: dbg_bus_fsm
// Carries out one bus transfer for each accepted start pulse.
// The request stays up with fixed address and data until a grant is seen.
// After the grant the block waits for an ack or an error.
// Assumes: start is only pulsed while busy is low, and the bus raises
// ack or err exactly once per grant.
module dbg_bus_fsm
    import dbg_client_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_we,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_wdata,
    output logic          busy,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_gnt,
    input  logic          bus_ack,
    input  logic          bus_err,
    input  logic [DW-1:0] bus_rdata,
    output logic          done,
    output logic          done_err,
    output logic [DW-1:0] done_data
);

    bus_st_e state;

    // Advance the transfer sequence and latch its operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state     <= ST_REQ;
                    bus_we    <= start_we;
                    bus_addr  <= start_addr;
                    bus_wdata <= start_wdata;
                end
                ST_REQ:  if (bus_gnt) state <= ST_WAIT;
                ST_WAIT: if (bus_ack || bus_err) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Produce the one-cycle completion pulse and its result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            done_err  <= 1'b0;
            done_data <= '0;
        end else begin
            done     <= (state == ST_WAIT) && (bus_ack || bus_err);
            done_err <= (state == ST_WAIT) && bus_err;
            if (state == ST_WAIT && (bus_ack || bus_err))
                done_data <= (bus_err || bus_we) ? '0 : bus_rdata;
        end
    end

    // Decode the request and busy indications from the state.
    always_comb begin
        bus_req = (state == ST_REQ);
        busy    = (state != ST_IDLE);
    end

    // R2
    stable_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_we) && $stable(bus_wdata)));

    // R10
    gnt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt) |=> !bus_req);

    // R5
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bus_req && bus_err) |=> (done && done_err && done_data == '0));

endmodule

// File: rtl/dbg_mailbox.sv
// Module: dbg_mailbox
// A one-word mailbox that monitor software fills and the host polls.
// A CPU write sets the full flag and a host read clears it. If both
// happen in the same cycle the write wins.
// Assumes: the host reads mbox_data in the same cycle as host_rd.
module dbg_mailbox #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_we,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          host_rd,
    output logic [DW-1:0] mbox_data,
    output logic          mbox_full
);

    // Store the CPU word and track whether the host has taken it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbox_data <= '0;
            mbox_full <= 1'b0;
        end else begin
            if (cpu_we) mbox_data <= cpu_wdata;
            if (cpu_we)       mbox_full <= 1'b1;
            else if (host_rd) mbox_full <= 1'b0;
        end
    end

    // R8
    mbox_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |=> (mbox_full && mbox_data == $past(cpu_wdata)));

endmodule

// File: rtl/dbg_ctrl_regs.sv
// Module: dbg_ctrl_regs
// Holds the sticky error flag and the bus request priority.
// Setting the error takes precedence over clearing it. The priority
// resets to 0, which is the lowest level.
// Assumes: the caller decodes set, clear and priority-write strobes.
module dbg_ctrl_regs
    import dbg_client_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_err,
    input  logic              clr_err,
    input  logic              prio_we,
    input  logic [PRIO_W-1:0] prio_wdata,
    output logic              err_flag,
    output logic [PRIO_W-1:0] prio
);

    // Update the sticky error flag, with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_flag <= 1'b0;
        else if (set_err) err_flag <= 1'b1;
        else if (clr_err) err_flag <= 1'b0;
    end

    // Load a new request priority on the host's command.
    always_ff @(posedge clk) begin
        if (!rst_n)       prio <= '0;
        else if (prio_we) prio <= prio_wdata;
    end

    // R9
    prio_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prio_we |=> (prio == $past(prio_wdata)));

endmodule

// File: rtl/dbg_bus_client.sv
// Module: dbg_bus_client (top)
// Decodes host requests into bus transfers, status reads, mailbox reads
// and priority writes. Bus operations that arrive while busy are
// rejected, and the rejection is recorded in the error flag.
// Assumes: DW >= 5 so that the status word fits; host_req is a
// one-cycle strobe.
module dbg_bus_client
    import dbg_client_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic [2:0]        host_op,
    input  logic [AW-1:0]     host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic              rsp_loc_valid,
    output logic [DW-1:0]     rsp_loc_data,
    output logic              rsp_bus_valid,
    output logic [DW-1:0]     rsp_bus_data,
    output logic              rsp_bus_err,
    input  logic              cpu_mbox_we,
    input  logic [DW-1:0]     cpu_mbox_wdata,
    output logic              bus_req,
    output logic [PRIO_W-1:0] bus_prio,
    input  logic              bus_gnt,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_we,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err
);

    localparam int STAT_W = STAT_PRIO_LO + PRIO_W;

    logic          is_bus_op, is_stat, is_mbox, is_prio;
    logic          start, reject, busy, done_err;
    logic          err_flag, mbox_full;
    logic [DW-1:0] mbox_data, status_word;

    // Decode the host operation code.
    always_comb begin
        is_bus_op = host_req && (host_op == OP_BUS_RD || host_op == OP_BUS_WR);
        is_stat   = host_req && (host_op == OP_STAT_RD);
        is_mbox   = host_req && (host_op == OP_MBOX_RD);
        is_prio   = host_req && (host_op == OP_PRIO_WR);
        start     = is_bus_op && !busy;
        reject    = is_bus_op && busy;
    end

    // Assemble the status word from the live flags.
    always_comb begin
        status_word = '0;
        status_word[STAT_BUSY] = busy;
        status_word[STAT_ERR]  = err_flag;
        status_word[STAT_FULL] = mbox_full;
        status_word[STAT_W-1:STAT_PRIO_LO] = bus_prio;
    end

    dbg_bus_fsm #(.AW(AW), .DW(DW)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_we    (host_op == OP_BUS_WR),
        .start_addr  (host_addr),
        .start_wdata (host_wdata),
        .busy        (busy),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_gnt     (bus_gnt),
        .bus_ack     (bus_ack),
        .bus_err     (bus_err),
        .bus_rdata   (bus_rdata),
        .done        (rsp_bus_valid),
        .done_err    (done_err),
        .done_data   (rsp_bus_data)
    );

    assign rsp_bus_err = done_err;

    dbg_mailbox #(.DW(DW)) i_mbox (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (cpu_mbox_we),
        .cpu_wdata (cpu_mbox_wdata),
        .host_rd   (is_mbox),
        .mbox_data (mbox_data),
        .mbox_full (mbox_full)
    );

    dbg_ctrl_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_err    (reject || done_err),
        .clr_err    (is_stat),
        .prio_we    (is_prio),
        .prio_wdata (host_wdata[PRIO_W-1:0]),
        .err_flag   (err_flag),
        .prio       (bus_prio)
    );

    // Register the reply to a status read or a mailbox read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_loc_valid <= 1'b0;
            rsp_loc_data  <= '0;
        end else begin
            rsp_loc_valid <= is_stat || is_mbox;
            if (is_stat)      rsp_loc_data <= status_word;
            else if (is_mbox) rsp_loc_data <= mbox_data;
        end
    end

    // R6
    reject_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bus_op && busy) |=> (err_flag && busy));

    // R2
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_bus_valid |-> $past(bus_ack || bus_err));

endmodule

// File: tb/test_dbg_bus_client.sv
// Bench for dbg_bus_client. It contains a bus slave model with a
// programmable grant delay, a walk through a table of vectors, and
// directed tests for reset and the corner cases.
module test_dbg_bus_client;
    import dbg_client_pkg::*;

    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic [2:0]    host_op = 3'd0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          rsp_loc_valid, rsp_bus_valid, rsp_bus_err;
    logic [DW-1:0] rsp_loc_data, rsp_bus_data;
    logic          cpu_mbox_we = 1'b0;
    logic [DW-1:0] cpu_mbox_wdata = '0;
    logic          bus_req, bus_we;
    logic [1:0]    bus_prio;
    logic          bus_gnt = 1'b0, bus_ack = 1'b0, bus_err = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;

    int checks = 0;
    int errors = 0;

    dbg_bus_client #(.AW(AW), .DW(DW)) i_dbg_bus_client (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_op(host_op),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .rsp_loc_valid(rsp_loc_valid), .rsp_loc_data(rsp_loc_data),
        .rsp_bus_valid(rsp_bus_valid), .rsp_bus_data(rsp_bus_data),
        .rsp_bus_err(rsp_bus_err), .cpu_mbox_we(cpu_mbox_we),
        .cpu_mbox_wdata(cpu_mbox_wdata), .bus_req(bus_req), .bus_prio(bus_prio),
        .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .bus_err(bus_err)
    );

    always #5 clk = ~clk;

    // Bus slave model: 16 words indexed by addr[3:0]; addresses with top nibble F fail.
    logic [DW-1:0] mem [16];
    int            gnt_delay = 0;
    int            gcnt = 0;
    bit            granted = 1'b0, ack_phase = 1'b0, req_after_gnt = 1'b0;
    int            n_access = 0;
    logic [AW-1:0] seen_addr;
    logic          seen_we;
    logic [DW-1:0] seen_wdata;

    initial for (int i = 0; i < 16; i++) mem[i] = '0;

    always @(negedge clk) begin
        bus_gnt = 1'b0;
        if (ack_phase) begin
            bus_ack = 1'b0; bus_err = 1'b0; ack_phase = 1'b0;
        end else if (granted) begin
            granted = 1'b0;
            if (bus_req) req_after_gnt = 1'b1;
            n_access++;
            if (seen_addr[AW-1:AW-4] == 4'hF) begin
                bus_err = 1'b1; bus_rdata = 32'hFFFF_FFFF;
            end else begin
                bus_ack = 1'b1;
                bus_rdata = mem[seen_addr[3:0]];
                if (seen_we) mem[seen_addr[3:0]] = seen_wdata;
            end
            ack_phase = 1'b1;
        end else if (bus_req) begin
            if (gcnt >= gnt_delay) begin
                bus_gnt = 1'b1; granted = 1'b1; gcnt = 0;
                seen_addr = bus_addr; seen_we = bus_we; seen_wdata = bus_wdata;
            end else gcnt++;
        end
    end

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] stat(input bit busy, input bit err,
                                           input bit full, input logic [1:0] prio);
        return {27'd0, prio, full, err, busy};
    endfunction

    // Drive one host request for one cycle; local replies are visible on return.
    task automatic host_issue(input logic [2:0] op, input logic [AW-1:0] a,
                              input logic [DW-1:0] d);
        @(negedge clk);
        host_req = 1'b1; host_op = op; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
    endtask

    task automatic wait_bus_done(input string req);
        int t = 0;
        while (!rsp_bus_valid && t < 60) begin @(negedge clk); t++; end
        if (!rsp_bus_valid) check(req, 32'd0, 32'd1);
    endtask

    typedef struct packed {
        logic [2:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] exp;
        logic [3:0]    gd;
        logic          experr;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 16'h0003, 32'hA5A5_0001, 32'h0,          4'd0, 1'b0}, // R3
        '{3'd0, 16'h0003, 32'h0,         32'hA5A5_0001,  4'd2, 1'b0}, // R2
        '{3'd1, 16'h7FF5, 32'h1234_5678, 32'h0,          4'd1, 1'b0}, // R3 R4
        '{3'd0, 16'h0105, 32'h0,         32'h1234_5678,  4'd0, 1'b0}, // R4
        '{3'd0, 16'hF000, 32'h0,         32'h0,          4'd3, 1'b1}, // R5
        '{3'd2, 16'h0,    32'h0,         32'h0000_0002,  4'd0, 1'b0}, // R7
        '{3'd2, 16'h0,    32'h0,         32'h0,          4'd0, 1'b0}, // R7
        '{3'd1, 16'hFFFA, 32'hDEAD_BEEF, 32'h0,          4'd0, 1'b1}, // R5 R4
        '{3'd2, 16'h0,    32'h0,         32'h0000_0002,  4'd0, 1'b0}  // R7
    };

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                check("watchdog", 32'd1, 32'd0);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 bus_req", {31'd0, bus_req}, 32'd0);
        check("R1 bus_prio", {30'd0, bus_prio}, 32'd0);
        host_issue(3'd2, '0, '0);
        check("R1 status", rsp_loc_data, stat(0, 0, 0, 2'd0));

        // Table walk: R2 R3 R4 R5 R7
        for (int v = 0; v < NV; v++) begin
            gnt_delay = int'(VECS[v].gd);
            host_issue(VECS[v].op, VECS[v].addr, VECS[v].wdata);
            if (VECS[v].op == 3'd2) begin
                check("R7 status valid", {31'd0, rsp_loc_valid}, 32'd1);
                check("R7 status word", rsp_loc_data, VECS[v].exp);
            end else begin
                wait_bus_done("R2 completion");
                check("R2 R3 R5 data", rsp_bus_data, VECS[v].exp);
                check("R5 err", {31'd0, rsp_bus_err}, {31'd0, VECS[v].experr});
                check("R4 addr", {16'd0, seen_addr}, {16'd0, VECS[v].addr});
                check("R2 R3 we", {31'd0, seen_we}, {31'd0, VECS[v].op == 3'd1});
                if (VECS[v].op == 3'd1)
                    check("R3 wdata", seen_wdata, VECS[v].wdata);
                @(negedge clk);
                check("R2 pulse one cycle", {31'd0, rsp_bus_valid}, 32'd0);
            end
        end
        host_issue(3'd2, '0, '0);   // clear error left by the last vector

        // R9 priority write, also while busy
        host_issue(3'd4, '0, 32'h2);
        check("R9 prio", {30'd0, bus_prio}, 32'd2);
        host_issue(3'd2, '0, '0);
        check("R9 status prio", rsp_loc_data, stat(0, 0, 0, 2'd2));

        // R6 reject while busy, R7 status while busy
        gnt_delay = 8;
        n_access = 0;
        host_issue(3'd0, 16'h0003, '0);
        host_issue(3'd1, 16'h0004, 32'h5555_5555);
        host_issue(3'd4, '0, 32'h1);
        check("R9 prio while busy", {30'd0, bus_prio}, 32'd1);
        host_issue(3'd2, '0, '0);
        check("R6 R7 busy status", rsp_loc_data, stat(1, 1, 0, 2'd1));
        wait_bus_done("R6 completion");
        check("R6 first access kept", rsp_bus_data, 32'hA5A5_0001);
        repeat (3) @(negedge clk);
        check("R6 single access", n_access, 32'd1);
        check("R6 word untouched", mem[4], 32'd0);
        host_issue(3'd2, '0, '0);
        check("R7 err cleared", rsp_loc_data, stat(0, 0, 0, 2'd1));
        gnt_delay = 0;

        // R8 mailbox
        @(negedge clk);
        cpu_mbox_we = 1'b1; cpu_mbox_wdata = 32'h0000_CAFE;
        @(negedge clk);
        cpu_mbox_we = 1'b0;
        host_issue(3'd2, '0, '0);
        check("R8 full set", rsp_loc_data, stat(0, 0, 1, 2'd1));
        host_issue(3'd3, '0, '0);
        check("R8 mailbox data", rsp_loc_data, 32'h0000_CAFE);
        host_issue(3'd2, '0, '0);
        check("R8 full cleared", rsp_loc_data, stat(0, 0, 0, 2'd1));
        // R8 simultaneous write and read
        @(negedge clk);
        cpu_mbox_we = 1'b1; cpu_mbox_wdata = 32'h0000_0011;
        @(negedge clk);
        cpu_mbox_we = 1'b1; cpu_mbox_wdata = 32'h0000_0022;
        host_req = 1'b1; host_op = 3'd3;
        @(negedge clk);
        cpu_mbox_we = 1'b0; host_req = 1'b0;
        check("R8 same-cycle old data", rsp_loc_data, 32'h0000_0011);
        host_issue(3'd2, '0, '0);
        check("R8 same-cycle stays full", rsp_loc_data, stat(0, 0, 1, 2'd1));

        // R10 request dropped after every grant
        check("R10 req after gnt", {31'd0, req_after_gnt}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule